// File: doc/BRIEF.md
# Posted Flash Write Buffer

This block sits between a processor's flash-write request port and the flash programmer. When posting is active, a write request is not sent straight on. Its address and data are parked in a single-entry holding slot, and the slot is released to the programmer when the compute engine's busy signal falls. Posting is active when a software-set mode bit and an engine-enable input are both 1. When posting is off, each write goes to the programmer on the next clock edge.

A pending output reports that the slot is occupied. A write that arrives while the slot is occupied is dropped, not stalled. If posting turns off while the slot is occupied, the held write is sent out at once.

The controller has two states. `ST_EMPTY` means no write is held. `ST_HELD` means one write is parked. The transitions are:

- **capture**: `ST_EMPTY` to `ST_HELD`, on a write while posting is active.
- **direct**: `ST_EMPTY` to `ST_EMPTY`, on a write while posting is inactive. The write is sent out.
- **drain**: `ST_HELD` to `ST_EMPTY`, on a falling edge of busy.
- **flush**: `ST_HELD` to `ST_EMPTY`, when posting becomes inactive.
- **wait**: `ST_HELD` to `ST_HELD`, otherwise. Any write that arrives is dropped.

Top module: `posted_wr_buf`

## Requirements
- R1: After reset, `pend` is 0, `fl_req` is 0 and `post_mode` is 0, so the block starts in immediate mode.
- R2: With `post_mode` 0, a `wr_req` pulse sampled at a clock edge makes `fl_req` 1 for the following cycle, with `fl_addr`/`fl_data` equal to that request's address and data.
- R3: With `post_mode` 1 but `eng_en` 0, writes are sent out immediately exactly as in R2.
- R4: With `post_mode` 1 and `eng_en` 1, a write sampled while `pend` is 0 sets `pend` to 1 after that edge and produces no `fl_req`.
- R5: A falling edge of `eng_busy` drains a held write. A falling edge means `eng_busy` was 1 at one clock edge and is 0 at the next. At that second edge `fl_req` goes to 1 for one cycle, carrying the held address and data, and `pend` goes to 0 at the same edge.
- R6: A write sampled while `pend` is 1 is dropped. `pend` stays 1, no `fl_req` results, and the later drain carries the first write's address and data.
- R7: If posting becomes inactive while `pend` is 1, the held write is sent out at the first clock edge where it is inactive, and `pend` clears. Posting becomes inactive when `eng_en` drops to 0, or when `post_mode` is cleared through the config write.
- R8: `eng_busy` held low, or rising, does not drain a held write. A busy falling edge while nothing is held produces no `fl_req`.
- R9: A config write (`cfg_we`=1) loads `cfg_post` into the mode bit. The bit is visible on `post_mode` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe for the mode bit |
| cfg_post | input | 1 | Value written to the mode bit |
| post_mode | output | 1 | Current mode bit (1 = posting requested) |
| eng_en | input | 1 | Compute engine enable |
| eng_busy | input | 1 | Compute engine busy |
| wr_req | input | 1 | Write request strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| pend | output | 1 | A posted write is held |
| fl_req | output | 1 | One-cycle request to the flash programmer |
| fl_addr | output | ADDR_W | Address sent to the programmer |
| fl_data | output | DATA_W | Data sent to the programmer |

## Verification
The hardest case to reach is a held write that is still held when a second write arrives. A drain must then follow and show that the first write's address and data survived.

The bench sweeps every mode-bit and engine-enable combination over several address/data patterns. After each capture, it drives a dropped write and then a low-busy cycle and a rising-busy cycle, none of which may drain. Only then does it make busy fall.

The flush paths are reached separately. One clears the mode bit, which takes effect one edge later. The other drops `eng_en` while a write is held.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } pwb_state_t;
endpackage

// File: rtl/pwb_fall_det.sv
module pwb_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic prev,
    output logic fall
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign fall = prev & ~lvl;
endmodule

// File: rtl/pwb_entry.sv
module pwb_entry #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
    import pwb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic posted,
    input  logic wr_req,
    input  logic fall,
    output logic held,
    output logic load,
    output logic issue_buf,
    output logic issue_dir
);
    pwb_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        nxt       = state;
        load      = 1'b0;
        issue_buf = 1'b0;
        issue_dir = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                if (wr_req) begin
                    if (posted) begin
                        load = 1'b1;          // capture
                        nxt  = ST_HELD;
                    end else begin
                        issue_dir = 1'b1;     // direct
                    end
                end
            end
            ST_HELD: begin
                if (!posted || fall) begin
                    issue_buf = 1'b1;         // flush or drain
                    nxt       = ST_EMPTY;
                end
            end
            default: nxt = ST_EMPTY;
        endcase
    end

    assign held = (state == ST_HELD);
endmodule

// File: rtl/posted_wr_buf.sv
module posted_wr_buf #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_post,
    output logic              post_mode,
    input  logic              eng_en,
    input  logic              eng_busy,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pend,
    output logic              fl_req,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_data
);
    localparam int EW = ADDR_W + DATA_W;

    logic          mode_q;
    logic          posted;
    logic          busy_prev, fall;
    logic          load, issue_buf, issue_dir;
    logic [EW-1:0] slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mode_q <= 1'b0;
        else if (cfg_we) mode_q <= cfg_post;
    end
    assign post_mode = mode_q;
    assign posted    = mode_q & eng_en;

    pwb_fall_det u_fall (
        .clk(clk), .rst_n(rst_n), .lvl(eng_busy), .prev(busy_prev), .fall(fall)
    );

    pwb_entry #(.W(EW)) u_slot (
        .clk(clk), .rst_n(rst_n), .load(load), .din({wr_addr, wr_data}), .dout(slot)
    );

    pwb_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .posted(posted), .wr_req(wr_req), .fall(fall),
        .held(pend), .load(load), .issue_buf(issue_buf), .issue_dir(issue_dir)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_req  <= 1'b0;
            fl_addr <= '0;
            fl_data <= '0;
        end else begin
            fl_req <= issue_buf | issue_dir;
            if (issue_dir) begin
                fl_addr <= wr_addr;
                fl_data <= wr_data;
            end else if (issue_buf) begin
                fl_addr <= slot[EW-1:DATA_W];
                fl_data <= slot[DATA_W-1:0];
            end
        end
    end

    AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !pend && !(post_mode && eng_en)) |=> (fl_req && fl_addr == $past(wr_addr) && fl_data == $past(wr_data))); // R2
    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !pend && post_mode && eng_en) |=> (pend && !fl_req)); // R4
    AST_DRAIN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && busy_prev && !eng_busy) |=> (fl_req && !pend)); // R5
    AST_DROP_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && wr_req && post_mode && eng_en && !(busy_prev && !eng_busy)) |=> (pend && !fl_req && $stable(slot))); // R6
    AST_FLUSH_ON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !(post_mode && eng_en)) |=> (fl_req && !pend)); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !wr_req) |=> !fl_req); // R8
endmodule

// File: tb/sim_posted_wr_buf.sv
module sim_posted_wr_buf;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0, cfg_post = 1'b0;
    logic          post_mode;
    logic          eng_en = 1'b0, eng_busy = 1'b0;
    logic          wr_req = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          pend, fl_req;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    posted_wr_buf #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_post(cfg_post), .post_mode(post_mode),
        .eng_en(eng_en), .eng_busy(eng_busy), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .pend(pend), .fl_req(fl_req), .fl_addr(fl_addr), .fl_data(fl_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_mode(input logic v);
        cfg_we = 1'b1; cfg_post = v;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_req = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_req = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        chk("R1 pend", pend, 0);
        chk("R1 fl_req", fl_req, 0);
        chk("R1 post_mode", post_mode, 0);
        rst_n = 1'b1;
        step();
        chk("R1 pend after release", pend, 0);

        // Sweep mode bit x engine enable x patterns
        for (int m = 0; m < 2; m++) begin
            set_mode(m[0]);
            chk("R9 post_mode", post_mode, m);
            for (int e = 0; e < 2; e++) begin
                eng_en = e[0];
                for (int i = 0; i < 4; i++) begin
                    logic [AW-1:0] a;
                    logic [DW-1:0] d;
                    a = AW'(16'h1000 + i * 37 + m * 8 + e * 4);
                    d = DW'(8'h5A ^ (i * 17));
                    pulse_wr(a, d);
                    if (!(m == 1 && e == 1)) begin
                        chk(m == 0 ? "R2 fl_req" : "R3 fl_req", fl_req, 1);
                        chk(m == 0 ? "R2 addr" : "R3 addr", fl_addr, a);
                        chk(m == 0 ? "R2 data" : "R3 data", fl_data, d);
                        chk("R2 pend", pend, 0);
                        step();
                    end else begin
                        chk("R4 pend", pend, 1);
                        chk("R4 no fl_req", fl_req, 0);
                        pulse_wr(~a, ~d);
                        chk("R6 pend kept", pend, 1);
                        chk("R6 no fl_req", fl_req, 0);
                        step();
                        chk("R8 low busy no drain", fl_req, 0);
                        eng_busy = 1'b1;
                        step();
                        chk("R8 rising busy no drain", fl_req, 0);
                        chk("R8 pend kept", pend, 1);
                        eng_busy = 1'b0;
                        step();
                        chk("R5 fl_req", fl_req, 1);
                        chk("R5 pend cleared", pend, 0);
                        chk("R6 drained addr is first", fl_addr, a);
                        chk("R6 drained data is first", fl_data, d);
                        step();
                        chk("R5 single pulse", fl_req, 0);
                    end
                end
            end
        end

        // R8: busy fall with nothing held
        eng_en = 1'b1; set_mode(1'b1);
        eng_busy = 1'b1; step();
        eng_busy = 1'b0; step();
        chk("R8 idle fall no req", fl_req, 0);

        // R7: engine enable drops while held
        pulse_wr(16'hBEEF, 8'h3C);
        chk("R7 held", pend, 1);
        eng_en = 1'b0;
        step();
        chk("R7 eng flush req", fl_req, 1);
        chk("R7 eng flush addr", fl_addr, 16'hBEEF);
        chk("R7 eng flush pend", pend, 0);
        eng_en = 1'b1;
        step();

        // R7: mode bit cleared while held (takes effect one edge later)
        pulse_wr(16'h0A0B, 8'hC3);
        chk("R7 held2", pend, 1);
        set_mode(1'b0);
        chk("R9 cleared", post_mode, 0);
        chk("R7 not yet", fl_req, 0);
        step();
        chk("R7 mode flush req", fl_req, 1);
        chk("R7 mode flush data", fl_data, 8'hC3);
        chk("R7 mode flush pend", pend, 0);

        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule